// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches a single active-low external interrupt pin and turns its activity into one interrupt request line for a CPU. The pin is first brought into the clock domain by a chain of synchronizer flops. A falling-edge detector then sets an interrupt latch. In level mode, a low level on the synchronized pin also holds that latch set.

Software reaches the block through one byte-wide control/status register on a simple read/write bus. That register shows the latched pending state. It also accepts a write-one acknowledge that clears the latch, and it holds two control bits. One control bit masks the request to the CPU. The other selects edge-only or edge-plus-level triggering. The mask gates only the request line, so the pending flag keeps recording pin events while the request is masked.

Top module: `extint_top`

## Requirements
- R1: After a synchronous active-high reset, `irqReq` is 0 and a read of the register returns 8'h00, with mask, mode and pending all clear.
- R2: A falling pin edge sets the pending flag (register bit 7) on the second rising clock edge after the edge that first samples the pin low. `irqReq` follows in the same cycle when the request is unmasked.
- R3: When the mode bit (bit 0) is 0, a pin held low after its falling edge does not set the latch again once the latch has been acknowledged.
- R4: When the mode bit is 1, the latch stays set while the synchronized pin is low, even across an acknowledge. It clears on an acknowledge only after the pin has returned high.
- R5: Writing a byte with bit 4 set to the register clears the latch on that clock edge. Bit 4 always reads as 0.
- R6: If a falling edge is detected in the same cycle as an acknowledge write, the latch stays set.
- R7: `irqReq` equals pending AND NOT mask, where the mask is bit 1. The pending flag still records edges while the mask is 1.
- R8: A read returns {pending, 0, 0, 0, 0, 0, mask, mode} when `busSel` is 1, `busWr` is 0 and `busAddr` equals `REG_ADDR`. Every other read returns 8'h00. Writes to bits 7, 6, 5, 3 and 2, and writes to any other address, change nothing.
- R9: A pin held low through reset is not taken as a falling edge once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pinN | input | 1 | Asynchronous active-low interrupt pin |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| irqReq | output | 1 | Interrupt request to the CPU |

## Verification
The hardest case to reach is an acknowledge write that lands in exactly the cycle in which the detector sees the falling edge. That cycle only exists two clocks after the pin is sampled low, so the stimulus has to count those clocks. A directed sequence lowers the pin and then issues the acknowledge on the third clock. The random phase meets the same collision by chance, because it mixes frequent acknowledge writes with slow pin toggles. A second hard case is a pin held low through reset. The bench keeps the pin low across a multi-cycle reset and checks that no request appears afterwards.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int DATA_W   = 8;
  localparam int PEND_BIT = 7;
  localparam int ACK_BIT  = 4;
  localparam int MASK_BIT = 1;
  localparam int MODE_BIT = 0;

  typedef struct packed {
    logic ackClear;
    logic levelEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pinN,
  input  ctrlStrobes_t strb,
  output logic         latchQ
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] syncQ;
  logic         syncPin;
  logic         prevQ;
  logic         fallEdge;
  logic         levelLow;

  // Synchronizer chain: not reset, it simply tracks the pin.
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) syncQ <= {syncQ[TOP-1:0], pinN};
    end else begin : g_single
      always_ff @(posedge clk) syncQ <= pinN;
    end
  endgenerate

  assign syncPin = syncQ[TOP];

  // History loads from the synchronizer even in reset, so a low pin held
  // through reset is never seen as an edge.
  always_ff @(posedge clk) prevQ <= syncPin;

  assign fallEdge = prevQ & ~syncPin;
  assign levelLow = strb.levelEn & ~syncPin;

  always_ff @(posedge clk) begin
    if (rst)                       latchQ <= 1'b0;
    else if (fallEdge || levelLow) latchQ <= 1'b1;
    else if (strb.ackClear)        latchQ <= 1'b0;
  end

  // R6
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (fallEdge && strb.ackClear) |=> latchQ);

  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.levelEn && !syncPin) |=> latchQ);

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.ackClear && !fallEdge && !(strb.levelEn && !syncPin)) |=> !latchQ);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !latchQ);
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              latchQ,
  output ctrlStrobes_t      strb,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqReq
);
  logic hit;
  logic wrHit;
  logic maskQ;
  logic modeQ;

  assign hit   = busSel && (busAddr == REG_ADDR);
  assign wrHit = hit && busWr;

  always_ff @(posedge clk) begin
    if (rst) begin
      maskQ <= 1'b0;
      modeQ <= 1'b0;
    end else if (wrHit) begin
      maskQ <= busWdata[MASK_BIT];
      modeQ <= busWdata[MODE_BIT];
    end
  end

  assign strb.ackClear = wrHit && busWdata[ACK_BIT];
  assign strb.levelEn  = modeQ;

  always_comb begin
    busRdata = '0;
    if (hit && !busWr) begin
      busRdata[PEND_BIT] = latchQ;
      busRdata[MASK_BIT] = maskQ;
      busRdata[MODE_BIT] = modeQ;
    end
  end

  assign irqReq = latchQ && !maskQ;

  // R8
  mask_write_chk: assert property (@(posedge clk) disable iff (rst)
    wrHit |=> (maskQ == $past(busWdata[MASK_BIT])));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wrHit && busWdata[MASK_BIT]) |=> !irqReq);
endmodule

// File: rtl/extint_top.sv
module extint_top
  import extint_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 4'h6,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pinN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              irqReq
);
  ctrlStrobes_t strb;
  logic         latchQ;

  extint_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst(rst), .pinN(pinN), .strb(strb), .latchQ(latchQ)
  );

  extint_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .latchQ(latchQ),
    .strb(strb), .busRdata(busRdata), .irqReq(irqReq)
  );
endmodule

// File: tb/sim_extint_top.sv
module sim_extint_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] RA = 4'h6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pinN = 1'b1;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irqReq;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  // bench-side expected state
  bit m1 = 1, m2 = 1, mPrev = 1, mLatch = 0, mMask = 0, mMode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extint_top #(.ADDR_W(4), .REG_ADDR(RA), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .pinN(pinN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqReq(irqReq)
  );

  function automatic logic [7:0] expRead();
    if (busSel && !busWr && busAddr == RA)
      return {mLatch, 5'b0, mMask, mMode};
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(logic sel, logic wr, logic [3:0] a, logic [7:0] d);
    busSel = sel; busWr = wr; busAddr = a; busWdata = d;
  endtask

  task automatic idle();
    bus(1'b0, 1'b0, 4'h0, 8'h00);
  endtask

  // one clock: update the model at the edge, compare just after it
  task automatic step(string tag);
    bit fall, lvl, ackW, wrHit;
    @(posedge clk);
    wrHit = busSel && busWr && (busAddr == RA);
    fall  = mPrev && !m2;
    lvl   = mMode && !m2;
    ackW  = wrHit && busWdata[4];
    if (rst) begin
      mLatch = 0; mMask = 0; mMode = 0;
    end else begin
      if (fall || lvl) mLatch = 1;
      else if (ackW)   mLatch = 0;
      if (wrHit) begin mMask = busWdata[1]; mMode = busWdata[0]; end
    end
    mPrev = m2; m2 = m1; m1 = pinN;
    #1;
    chk({tag, " irq"}, {7'b0, irqReq}, {7'b0, mLatch && !mMask});
    if (busSel && !busWr) chk({tag, " read"}, busRdata, expRead());
    @(negedge clk);
  endtask

  task automatic finish();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      finish();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1: reset state
    rst = 1; pinN = 1; idle();
    repeat (4) step("R1");
    rst = 0; step("R1");
    bus(1, 0, RA, 0); step("R1");
    chk("R1 reset read", busRdata, 8'h00);
    chk("R1 reset irq", {7'b0, irqReq}, 8'h00);

    // R2: latency of a falling edge
    idle(); pinN = 0; step("R2");
    chk("R2 edge+0", {7'b0, irqReq}, 8'h00);
    step("R2");
    chk("R2 edge+1", {7'b0, irqReq}, 8'h00);
    step("R2");
    chk("R2 edge+2", {7'b0, irqReq}, 8'h01);

    // R3: edge-only, held low, ack clears for good
    bus(1, 1, RA, 8'h10); step("R3");
    idle(); repeat (4) step("R3");
    chk("R3 held low after ack", {7'b0, irqReq}, 8'h00);

    // R4: level mode holds latch while low
    pinN = 1; repeat (3) step("R4");
    bus(1, 1, RA, 8'h01); step("R4");
    idle(); pinN = 0; repeat (3) step("R4");
    bus(1, 1, RA, 8'h11); step("R4");
    idle(); step("R4");
    chk("R4 level hold over ack", {7'b0, irqReq}, 8'h01);
    pinN = 1; repeat (3) step("R4");
    bus(1, 1, RA, 8'h11); step("R5");
    idle(); step("R5");
    chk("R5 ack clears after pin high", {7'b0, irqReq}, 8'h00);

    // R6: edge and ack in the same cycle
    bus(1, 1, RA, 8'h00); step("R6");
    idle(); repeat (3) step("R6");
    pinN = 0; step("R6"); step("R6");
    bus(1, 1, RA, 8'h10); step("R6");
    idle(); step("R6");
    chk("R6 edge beats ack", {7'b0, irqReq}, 8'h01);
    bus(1, 1, RA, 8'h10); step("R6"); idle(); step("R6");

    // R7: mask gates request only
    bus(1, 1, RA, 8'h02); step("R7");
    idle(); pinN = 1; repeat (3) step("R7");
    pinN = 0; repeat (3) step("R7");
    chk("R7 masked irq", {7'b0, irqReq}, 8'h00);
    bus(1, 0, RA, 0); step("R7");
    chk("R7 pending while masked", busRdata, 8'h82);
    bus(1, 1, RA, 8'h00); step("R7");
    idle(); step("R7");
    chk("R7 unmasked irq", {7'b0, irqReq}, 8'h01);

    // R8: ignored bits and other addresses
    bus(1, 1, RA, 8'hEC); step("R8");
    bus(1, 0, RA, 0); step("R8");
    chk("R8 reserved write", busRdata, 8'h80);
    bus(1, 1, 4'h3, 8'h13); step("R8");
    bus(1, 0, RA, 0); step("R8");
    chk("R8 other-address write", busRdata, 8'h80);
    bus(1, 0, 4'h3, 0); step("R8");
    chk("R8 other-address read", busRdata, 8'h00);

    // R9: pin low through reset
    idle(); pinN = 0; rst = 1; repeat (3) step("R9");
    rst = 0; repeat (4) step("R9");
    bus(1, 0, RA, 0); step("R9");
    chk("R9 no false edge", busRdata, 8'h00);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) pinN = ~pinN;
      rst = ($urandom_range(299) == 0);
      bus($urandom_range(1), $urandom_range(1),
          ($urandom_range(3) == 0) ? 4'($urandom_range(15)) : RA,
          8'($urandom_range(255)));
      step("random");
    end
    rst = 0; idle(); step("random");
    finish();
  end
endmodule